// File: doc/BRIEF.md
# Memory Address-Range Protection Checker

This block sits in front of a memory controller and decides, for every transaction, whether it may proceed. It keeps a table of twenty protection rules. Each rule covers an inclusive span of one-megabyte address windows, an inclusive range of transaction IDs, a set of source ports and a set of allowed security attributes, and it carries a verdict of accept or reject. A ten-bit fallback mask chooses the verdict, port by port, for traffic that no rule covers.

Software never addresses a rule directly. It fills three staging registers (address span, ID span, rule attributes) and then issues a command that names a rule and either commits the staged words into that rule or fetches that rule back into the staging registers. The transaction side is a plain request with address, ID, port and security attribute. The verdict is registered and appears one cycle after the request.

Top module: `mem_range_guard`

## Requirements
- R1: After reset every rule is invalid and the fallback mask is zero, so every transaction is accepted and `resp_valid` is low until a request arrives.
- R2: `cfg_sel` selects the register for a `cfg_we` write and drives `cfg_rdata` combinationally: 0 command, 1 address span (bits 23:0), 2 ID span (bits 23:0), 3 attributes (bits 13:0), 4 fallback mask (bits 9:0). Unused bits and codes 5 to 7 read as 0, and a staging write is visible from the next cycle.
- R3: A command write stores bits 4:0 as the rule number. With bit 5 set it copies the three staging registers into that rule at the same clock edge. Rule numbers 20 to 31 leave the table unchanged.
- R4: A command write with bit 6 set and bit 5 clear loads the named rule into the staging registers at that edge, and if both bits are set only the copy into the rule happens. Reading the command register returns only the rule number.
- R5: A rule covers an address when address bits 31:20 lie in [span bits 11:0, span bits 23:12] inclusive.
- R6: A rule covers an ID when it lies in [ID bits 11:0, ID bits 23:12] inclusive.
- R7: A rule takes part only when attribute bit 2 (valid) is set and attribute bit 3+p is set for the requesting port p.
- R8: Attribute bits 1:0 are the allowed security attributes. The request carries `txn_sec`, where 2'b01 is secure and 2'b10 is non-secure. The rule matches only when the bitwise AND of `txn_sec` and those two bits is nonzero.
- R9: Attribute bit 13 is the verdict, 1 for reject and 0 for accept. If any matching rule rejects, the request is rejected. Otherwise a matching accept rule accepts it.
- R10: When no rule matches, the verdict is the fallback mask bit of the port. A port number of 10 or more is always rejected unless a rule matches it, and no rule can match it.
- R11: `resp_valid` follows `txn_valid` by exactly one cycle, and `resp_reject` is 0 whenever `resp_valid` is 0. A request in the same cycle as a rule commit is judged against the table as it was before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Selected register contents |
| txn_valid | input | 1 | Transaction request present |
| txn_addr | input | 32 | Transaction byte address |
| txn_id | input | 12 | Transaction ID |
| txn_port | input | 4 | Source port number |
| txn_sec | input | 2 | Security attribute (01 secure, 10 non-secure) |
| resp_valid | output | 1 | Verdict present, one cycle after the request |
| resp_reject | output | 1 | 1 rejects the transaction, 0 accepts it |

## Verification
The two functions that can meet in one cycle are a rule commit (or a fetch back into the staging registers) and the check of an incoming transaction against the same rule. A long random phase drives command writes and transactions together on the same clock, using small address and ID spaces so that the rule being rewritten is often the one that decides the verdict. A behavioural model in the bench takes its verdict from its table before it applies that edge's command, and it compares the verdict, the valid flag and the read-back data on every cycle.

// File: rtl/mrg_pkg.sv
// Package: shared rule layout, register select codes and pack/unpack helpers
// for the address-range protection checker.
// Assumes: 12-bit megabyte bounds, 12-bit IDs, 10 ports, 5-bit rule number.
package mrg_pkg;

    localparam int BOUND_W   = 12;
    localparam int ID_W      = 12;
    localparam int PORT_CNT  = 10;
    localparam int PORT_W    = $clog2(PORT_CNT);
    localparam int RULE_CNT  = 20;
    localparam int CMD_IDX_W = 5;
    localparam int CMD_WR_B  = 5;
    localparam int CMD_RD_B  = 6;
    localparam int SPAN_W    = 2 * BOUND_W;
    localparam int IDS_W     = 2 * ID_W;
    localparam int ATTR_W    = 4 + PORT_CNT;

    typedef enum logic [2:0] {
        SEL_CMD  = 3'd0,
        SEL_SPAN = 3'd1,
        SEL_IDS  = 3'd2,
        SEL_ATTR = 3'd3,
        SEL_DFLT = 3'd4
    } cfg_sel_e;

    typedef struct packed {
        logic                result;
        logic [PORT_CNT-1:0] port_mask;
        logic                valid;
        logic [1:0]          sec;
        logic [ID_W-1:0]     id_hi;
        logic [ID_W-1:0]     id_lo;
        logic [BOUND_W-1:0]  mb_hi;
        logic [BOUND_W-1:0]  mb_lo;
    } rule_t;

    // Build a rule from the three staging words.
    function automatic rule_t pack_rule(input logic [SPAN_W-1:0] span,
                                        input logic [IDS_W-1:0]  ids,
                                        input logic [ATTR_W-1:0] attr);
        rule_t r;
        r.mb_lo     = span[BOUND_W-1:0];
        r.mb_hi     = span[SPAN_W-1:BOUND_W];
        r.id_lo     = ids[ID_W-1:0];
        r.id_hi     = ids[IDS_W-1:ID_W];
        r.sec       = attr[1:0];
        r.valid     = attr[2];
        r.port_mask = attr[PORT_CNT+2:3];
        r.result    = attr[ATTR_W-1];
        return r;
    endfunction

    function automatic logic [SPAN_W-1:0] span_of(input rule_t r);
        return {r.mb_hi, r.mb_lo};
    endfunction

    function automatic logic [IDS_W-1:0] ids_of(input rule_t r);
        return {r.id_hi, r.id_lo};
    endfunction

    function automatic logic [ATTR_W-1:0] attr_of(input rule_t r);
        return {r.result, r.port_mask, r.valid, r.sec};
    endfunction

endpackage

// File: rtl/mrg_cfg_regs.sv
// Module: staging registers, fallback mask and command decode.
// Decodes commit/fetch strobes for the rule table and returns the selected
// register on cfg_rdata. Assumes one register access per cycle.
module mrg_cfg_regs
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_CNT,
    parameter int DATA_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_sel,
    input  logic [DATA_W-1:0]    cfg_wdata,
    output logic [DATA_W-1:0]    cfg_rdata,
    input  rule_t                fetch_rule,
    output logic [CMD_IDX_W-1:0] cmd_idx,
    output logic                 commit_en,
    output rule_t                staged_rule,
    output logic [PORT_CNT-1:0]  dflt_mask
);

    logic [SPAN_W-1:0]    st_span;
    logic [IDS_W-1:0]     st_ids;
    logic [ATTR_W-1:0]    st_attr;
    logic [CMD_IDX_W-1:0] last_idx;
    logic                 cmd_wr;
    logic                 idx_ok;
    logic                 fetch_en;

    // Decode the command word presented in this cycle.
    always_comb begin
        cmd_wr    = cfg_we && (cfg_sel == SEL_CMD);
        cmd_idx   = cfg_wdata[CMD_IDX_W-1:0];
        idx_ok    = (int'(cmd_idx) < NUM_RULES);
        commit_en = cmd_wr && idx_ok && cfg_wdata[CMD_WR_B];
        fetch_en  = cmd_wr && idx_ok && !cfg_wdata[CMD_WR_B] && cfg_wdata[CMD_RD_B];
    end

    // Staging registers: written by software or loaded from a fetched rule.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_span <= '0;
            st_ids  <= '0;
            st_attr <= '0;
        end else if (fetch_en) begin
            st_span <= span_of(fetch_rule);
            st_ids  <= ids_of(fetch_rule);
            st_attr <= attr_of(fetch_rule);
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_SPAN: st_span <= cfg_wdata[SPAN_W-1:0];
                SEL_IDS:  st_ids  <= cfg_wdata[IDS_W-1:0];
                SEL_ATTR: st_attr <= cfg_wdata[ATTR_W-1:0];
                default:  ;
            endcase
        end
    end

    // Fallback mask and last rule number written to the command register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dflt_mask <= '0;
            last_idx  <= '0;
        end else if (cfg_we) begin
            if (cfg_sel == SEL_DFLT) dflt_mask <= cfg_wdata[PORT_CNT-1:0];
            if (cfg_sel == SEL_CMD)  last_idx  <= cmd_idx;
        end
    end

    // Present the staged words as one rule for the table write port.
    always_comb begin
        staged_rule = pack_rule(st_span, st_ids, st_attr);
    end

    // Read multiplexer for the selected register.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_CMD:  cfg_rdata[CMD_IDX_W-1:0] = last_idx;
            SEL_SPAN: cfg_rdata[SPAN_W-1:0]    = st_span;
            SEL_IDS:  cfg_rdata[IDS_W-1:0]     = st_ids;
            SEL_ATTR: cfg_rdata[ATTR_W-1:0]    = st_attr;
            SEL_DFLT: cfg_rdata[PORT_CNT-1:0]  = dflt_mask;
            default:  cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/mrg_rule_table.sv
// Module: rule storage with one write port and one combinational read port.
// Assumes the write index has already been range checked by the decoder.
module mrg_rule_table
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_CNT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [CMD_IDX_W-1:0] idx,
    input  rule_t                wr_rule,
    output rule_t                rd_rule,
    output rule_t                rules_o [NUM_RULES]
);

    genvar g;
    generate
        for (g = 0; g < NUM_RULES; g++) begin : g_rule
            // One rule slot: cleared to invalid on reset, loaded on commit.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    rules_o[g] <= '0;
                else if (wr_en && (int'(idx) == g))
                    rules_o[g] <= wr_rule;
            end
        end
    endgenerate

    // Read port used by the fetch command; out-of-range reads give zero.
    always_comb begin
        rd_rule = '0;
        for (int k = 0; k < NUM_RULES; k++) begin
            if (int'(idx) == k) rd_rule = rules_o[k];
        end
    end

endmodule

// File: rtl/mrg_match.sv
// Module: combinational rule matching and verdict resolution.
// A reject hit wins over an accept hit; with no hit the port fallback bit
// decides, and ports outside the implemented range are rejected.
module mrg_match
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_CNT,
    parameter int ADDR_W    = 32
) (
    input  rule_t               rules_i [NUM_RULES],
    input  logic [ADDR_W-1:0]   addr,
    input  logic [ID_W-1:0]     id,
    input  logic [PORT_W-1:0]   port,
    input  logic [1:0]          sec,
    input  logic [PORT_CNT-1:0] dflt_mask,
    output logic                reject
);

    localparam int MB_LSB = ADDR_W - BOUND_W;

    logic [BOUND_W-1:0]   mb;
    logic                 port_ok;
    logic [NUM_RULES-1:0] hit;
    logic [NUM_RULES-1:0] hit_rej;
    logic [NUM_RULES-1:0] hit_acc;

    // Megabyte index and port range check shared by all rules.
    always_comb begin
        mb      = addr[ADDR_W-1:MB_LSB];
        port_ok = (int'(port) < PORT_CNT);
    end

    genvar g;
    generate
        for (g = 0; g < NUM_RULES; g++) begin : g_cmp
            // Per-rule comparison of every transaction field.
            always_comb begin
                hit[g] = rules_i[g].valid
                      && port_ok && rules_i[g].port_mask[port]
                      && (id >= rules_i[g].id_lo) && (id <= rules_i[g].id_hi)
                      && (mb >= rules_i[g].mb_lo) && (mb <= rules_i[g].mb_hi)
                      && ((sec & rules_i[g].sec) != 2'b00);
                hit_rej[g] = hit[g] && rules_i[g].result;
                hit_acc[g] = hit[g] && !rules_i[g].result;
            end
        end
    endgenerate

    // Resolve the verdict from the hit vectors and the fallback mask.
    always_comb begin
        if (|hit_rej)
            reject = 1'b1;
        else if (|hit_acc)
            reject = 1'b0;
        else if (!port_ok)
            reject = 1'b1;
        else
            reject = dflt_mask[port];
    end

endmodule

// File: rtl/mem_range_guard.sv
// Module: top of the address-range protection checker.
// Joins the register front end, the rule table and the match logic, and
// registers the verdict so it appears one cycle after the request.
module mem_range_guard
    import mrg_pkg::*;
#(
    parameter int NUM_RULES = RULE_CNT,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              txn_valid,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [ID_W-1:0]   txn_id,
    input  logic [PORT_W-1:0] txn_port,
    input  logic [1:0]        txn_sec,
    output logic              resp_valid,
    output logic              resp_reject
);

    logic [CMD_IDX_W-1:0] cmd_idx;
    logic                 commit_en;
    rule_t                staged_rule;
    rule_t                fetch_rule;
    rule_t                rules [NUM_RULES];
    logic [PORT_CNT-1:0]  dflt_mask;
    logic                 verdict;

    mrg_cfg_regs #(.NUM_RULES(NUM_RULES), .DATA_W(DATA_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .cfg_rdata   (cfg_rdata),
        .fetch_rule  (fetch_rule),
        .cmd_idx     (cmd_idx),
        .commit_en   (commit_en),
        .staged_rule (staged_rule),
        .dflt_mask   (dflt_mask)
    );

    mrg_rule_table #(.NUM_RULES(NUM_RULES)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit_en),
        .idx     (cmd_idx),
        .wr_rule (staged_rule),
        .rd_rule (fetch_rule),
        .rules_o (rules)
    );

    mrg_match #(.NUM_RULES(NUM_RULES), .ADDR_W(ADDR_W)) u_match (
        .rules_i   (rules),
        .addr      (txn_addr),
        .id        (txn_id),
        .port      (txn_port),
        .sec       (txn_sec),
        .dflt_mask (dflt_mask),
        .reject    (verdict)
    );

    // Output stage: verdict registered only for real requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_reject <= 1'b0;
        end else begin
            resp_valid  <= txn_valid;
            resp_reject <= txn_valid && verdict;
        end
    end

endmodule

// File: rtl/mrg_checker.sv
// Module: protocol assertions for mem_range_guard, attached by bind.
// Observes only top-level ports.
module mrg_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [2:0]  cfg_sel,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        txn_valid,
    input logic        resp_valid,
    input logic        resp_reject
);

    AST_RESET_CLEARS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> !resp_valid && !resp_reject); // R1

    AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        txn_valid |=> resp_valid); // R11

    AST_IDLE_NO_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        !txn_valid |=> !resp_valid && !resp_reject); // R11

    AST_CMD_READS_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 3'd0) |-> (cfg_rdata[31:5] == 27'd0)); // R4

    AST_DFLT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel == 3'd4) |-> (cfg_rdata[31:10] == 22'd0)); // R2

    AST_SPAN_WRITE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_sel == 3'd1) ##1 (cfg_sel == 3'd1)
        |-> (cfg_rdata == {8'd0, $past(cfg_wdata[23:0])})); // R2

endmodule

bind mem_range_guard mrg_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .cfg_rdata   (cfg_rdata),
    .txn_valid   (txn_valid),
    .resp_valid  (resp_valid),
    .resp_reject (resp_reject)
);

// File: tb/tb_mem_range_guard.sv
// Bench: behavioural reference model compared with the design on every clock.
module tb_mem_range_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = 3'd0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        txn_valid = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [11:0] txn_id = '0;
    logic [3:0]  txn_port = '0;
    logic [1:0]  txn_sec = 2'b01;
    logic        resp_valid;
    logic        resp_reject;

    int compared = 0;
    int mismatched = 0;
    bit checks_on = 0;
    string cur_req = "R1";

    // Reference model state
    int unsigned m_span [20];
    int unsigned m_ids  [20];
    int unsigned m_attr [20];
    int unsigned s_span, s_ids, s_attr, m_dflt, m_idx;
    bit exp_v, exp_r;

    always #5 clk = ~clk;

    mem_range_guard dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .txn_valid(txn_valid),
        .txn_addr(txn_addr), .txn_id(txn_id), .txn_port(txn_port),
        .txn_sec(txn_sec), .resp_valid(resp_valid), .resp_reject(resp_reject)
    );

    function automatic bit m_decide(int unsigned addr, int unsigned id,
                                    int unsigned port, int unsigned sec);
        bit rej = 0, acc = 0;
        int unsigned mb = addr >> 20;
        for (int k = 0; k < 20; k++) begin
            int unsigned a = m_attr[k];
            if (((a >> 2) & 1) == 1 && port < 10 && ((a >> (3 + port)) & 1) == 1 &&
                id >= (m_ids[k] & 12'hFFF) && id <= (m_ids[k] >> 12) &&
                mb >= (m_span[k] & 12'hFFF) && mb <= (m_span[k] >> 12) &&
                (sec & a & 3) != 0) begin
                if (((a >> 13) & 1) == 1) rej = 1; else acc = 1;
            end
        end
        if (rej) return 1;
        if (acc) return 0;
        if (port >= 10) return 1;
        return bit'((m_dflt >> port) & 1);
    endfunction

    // Model update on each clock edge, using the inputs sampled there.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 20; k++) begin
                m_span[k] = 0; m_ids[k] = 0; m_attr[k] = 0;
            end
            s_span = 0; s_ids = 0; s_attr = 0; m_dflt = 0; m_idx = 0;
            exp_v = 0; exp_r = 0;
        end else begin
            exp_v = txn_valid;
            exp_r = txn_valid ? m_decide(txn_addr, txn_id, txn_port, txn_sec) : 1'b0;
            if (cfg_we) begin
                case (cfg_sel)
                    3'd0: begin
                        m_idx = cfg_wdata & 32'h1F;
                        if (m_idx < 20 && cfg_wdata[5]) begin
                            m_span[m_idx] = s_span; m_ids[m_idx] = s_ids;
                            m_attr[m_idx] = s_attr;
                        end else if (m_idx < 20 && cfg_wdata[6]) begin
                            s_span = m_span[m_idx]; s_ids = m_ids[m_idx];
                            s_attr = m_attr[m_idx];
                        end
                    end
                    3'd1: s_span = cfg_wdata & 32'hFFFFFF;
                    3'd2: s_ids  = cfg_wdata & 32'hFFFFFF;
                    3'd3: s_attr = cfg_wdata & 32'h3FFF;
                    3'd4: m_dflt = cfg_wdata & 32'h3FF;
                    default: ;
                endcase
            end
        end
    end

    function automatic int unsigned m_rdata(logic [2:0] sel);
        case (sel)
            3'd0: return m_idx;
            3'd1: return s_span;
            3'd2: return s_ids;
            3'd3: return s_attr;
            3'd4: return m_dflt;
            default: return 0;
        endcase
    endfunction

    task automatic cmp(string what, int unsigned act, int unsigned exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Advance one clock, then compare after the edge has settled.
    task automatic tick();
        @(posedge clk);
        #2;
        if (checks_on) begin
            cmp("resp_valid", resp_valid, exp_v);
            cmp("resp_reject", resp_reject, exp_r);
            cmp("cfg_rdata", cfg_rdata, m_rdata(cfg_sel));
        end
    endtask

    task automatic wr(logic [2:0] sel, logic [31:0] d);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
        tick();
        cfg_we = 0;
    endtask

    task automatic rd(logic [2:0] sel);
        cfg_sel = sel;
        tick();
    endtask

    task automatic txn(logic [31:0] a, logic [11:0] id, logic [3:0] p, logic [1:0] s);
        txn_valid = 1; txn_addr = a; txn_id = id; txn_port = p; txn_sec = s;
        tick();
        txn_valid = 0;
        tick();
    endtask

    task automatic set_rule(int no, int mlo, int mhi, int ilo, int ihi,
                            int sec, int vld, int pm, int res);
        wr(3'd1, 32'((mhi << 12) | mlo));
        wr(3'd2, 32'((ihi << 12) | ilo));
        wr(3'd3, 32'((res << 13) | (pm << 3) | (vld << 2) | sec));
        wr(3'd0, 32'(no | 32));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        checks_on = 1;
        // R1: reset state accepts everything, fallback mask reads 0
        cur_req = "R1";
        tick();
        rd(3'd4);
        txn(32'hFFF0_0000, 12'hABC, 4'd9, 2'b10);
        txn(32'h0000_0000, 12'h000, 4'd0, 2'b01);
        // R2: register select codes and widths
        cur_req = "R2";
        for (int s = 1; s < 8; s++) begin
            wr(3'(s), 32'hFFFF_FFFF);
            rd(3'(s));
        end
        wr(3'd4, 32'h0);
        // R3: commit rule 0 accepting 0..255 MB, reject everything else
        cur_req = "R3";
        set_rule(0, 12'h000, 12'h0FF, 0, 12'hFFF, 3, 1, 10'h3FF, 0);
        wr(3'd4, 32'h3FF);
        txn(32'h0FF0_0000, 12'h123, 4'd3, 2'b01);
        txn(32'h1000_0000, 12'h123, 4'd3, 2'b01);
        set_rule(25, 12'h000, 12'hFFF, 0, 12'hFFF, 3, 1, 10'h3FF, 1);
        rd(3'd0);
        txn(32'h0010_0000, 12'h001, 4'd1, 2'b10);
        // R4: fetch rule 0 back; both strobes commit only
        cur_req = "R4";
        wr(3'd1, 0); wr(3'd2, 0); wr(3'd3, 0);
        wr(3'd0, 32'h40);
        rd(3'd1); rd(3'd2); rd(3'd3); rd(3'd0);
        wr(3'd0, 32'h73);
        rd(3'd1); rd(3'd3);
        // R5: address bounds inclusive
        cur_req = "R5";
        set_rule(1, 12'h200, 12'h20F, 0, 12'hFFF, 3, 1, 10'h3FF, 0);
        txn(32'h2000_0000, 0, 4'd0, 2'b01);
        txn(32'h20FF_FFFF, 0, 4'd0, 2'b01);
        txn(32'h1FFF_FFFF, 0, 4'd0, 2'b01);
        txn(32'h2100_0000, 0, 4'd0, 2'b01);
        // R6: ID bounds inclusive
        cur_req = "R6";
        set_rule(2, 12'h300, 12'h300, 12'h010, 12'h020, 3, 1, 10'h3FF, 0);
        txn(32'h3000_0000, 12'h010, 4'd2, 2'b01);
        txn(32'h3000_0000, 12'h020, 4'd2, 2'b01);
        txn(32'h3000_0000, 12'h021, 4'd2, 2'b01);
        txn(32'h3000_0000, 12'h00F, 4'd2, 2'b01);
        // R7: valid bit and port mask
        cur_req = "R7";
        set_rule(3, 12'h400, 12'h400, 0, 12'hFFF, 3, 1, 10'h004, 0);
        txn(32'h4000_0000, 0, 4'd2, 2'b01);
        txn(32'h4000_0000, 0, 4'd3, 2'b01);
        set_rule(3, 12'h400, 12'h400, 0, 12'hFFF, 3, 0, 10'h3FF, 0);
        txn(32'h4000_0000, 0, 4'd2, 2'b01);
        // R8: security permission bits
        cur_req = "R8";
        set_rule(4, 12'h500, 12'h500, 0, 12'hFFF, 1, 1, 10'h3FF, 0);
        txn(32'h5000_0000, 0, 4'd1, 2'b01);
        txn(32'h5000_0000, 0, 4'd1, 2'b10);
        txn(32'h5000_0000, 0, 4'd1, 2'b00);
        // R9: overlapping accept and reject, reject wins
        cur_req = "R9";
        set_rule(5, 12'h000, 12'h0FF, 0, 12'hFFF, 3, 1, 10'h3FF, 1);
        txn(32'h0050_0000, 0, 4'd4, 2'b01);
        set_rule(5, 12'h000, 12'h0FF, 0, 12'hFFF, 3, 0, 10'h3FF, 1);
        // R10: fallback mask per port and out-of-range ports
        cur_req = "R10";
        wr(3'd4, 32'h155);
        txn(32'hF000_0000, 0, 4'd0, 2'b01);
        txn(32'hF000_0000, 0, 4'd1, 2'b01);
        txn(32'h0000_0000, 0, 4'd12, 2'b01);
        wr(3'd4, 32'h0);
        txn(32'hF000_0000, 0, 4'd15, 2'b10);
        // R11: random mix, commands and requests in the same cycle
        cur_req = "R11";
        for (int n = 0; n < 6000; n++) begin
            int unsigned pick = $urandom % 8;
            cfg_we = ($urandom % 2) == 1;
            cfg_sel = (pick < 3) ? 3'd0 : 3'($urandom % 6);
            case (cfg_sel)
                3'd0: cfg_wdata = ($urandom % 24) | (($urandom % 4) << 5);
                3'd1: cfg_wdata = (($urandom % 16) << 12) | ($urandom % 16);
                3'd2: cfg_wdata = (($urandom % 32) << 12) | ($urandom % 32);
                3'd3: cfg_wdata = ($urandom & 32'h3FFF) | (($urandom % 4 != 0) ? 4 : 0);
                default: cfg_wdata = $urandom;
            endcase
            txn_valid = ($urandom % 4) != 0;
            txn_addr = (($urandom % 16) << 20) | ($urandom & 32'hFFFFF);
            txn_id = 12'($urandom % 32);
            txn_port = 4'($urandom % 12);
            txn_sec = 2'($urandom);
            tick();
        end
        cfg_we = 0; txn_valid = 0;
        tick(); tick();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule